// File: doc/BRIEF.md
# Two's-Complement Lookahead Adder-Subtractor

This block adds or subtracts two signed two's-complement words of a configurable width. It returns the sum or the difference, the carry out of the top bit and a signed-overflow flag. Subtraction adds the bit-inverted second operand and forces a carry of one into the lowest bit. Carries are formed by two-level generate/propagate expressions inside each 4-bit slice. The carry out of each slice feeds the next slice.

An optional output register sits on all three outputs and is on by default. Overflow is computed in two independent ways. The primary way compares the carry entering the sign position with the carry leaving it. The second way adds copies of the operands that carry an extra duplicated sign bit and checks whether the two top bits of that wider sum agree. The package also provides a sign-extension helper for moving words between widths.

Top module: `addsubTop`

## Requirements
- R1: When `subMode` is 0, `{carryOut, result}` equals the unsigned sum `opA + opB + carryIn`, taken over W+1 bits. Any carry beyond the top bit is left out of `result`.
- R2: When `subMode` is 1, `result` equals `opA + ~opB + 1` modulo 2^W, and `carryIn` has no effect. In this mode `carryOut` is 1 exactly when the unsigned value of `opA` is at least that of `opB`, that is, when no borrow occurs.
- R3: `overflow` is 1 exactly when the signed result of the selected operation falls outside -2^(W-1) to 2^(W-1)-1. This matches the condition where the carry into the sign bit differs from the carry out of it. When it is set, the sign of `result` differs from the sign of `opA`.
- R4: The doubled-sign-bit overflow check always agrees with the sign-carry check.
- R5: The most negative value -2^(W-1) has no positive counterpart. Subtracting it from zero sets `overflow` and returns -2^(W-1) itself.
- R6: With the output register enabled, which is the default, results appear one clock after their operands are sampled. While `rstN` is low, `result`, `carryOut` and `overflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Active-low synchronous reset that clears the outputs |
| opA | input | W | First operand, and the minuend in subtract mode |
| opB | input | W | Second operand, and the subtrahend in subtract mode |
| subMode | input | 1 | 1 selects subtraction, 0 selects addition |
| carryIn | input | 1 | Carry into bit 0, used in add mode only |
| result | output | W | Sum or difference, modulo 2^W |
| carryOut | output | 1 | Carry out of the most significant bit |
| overflow | output | 1 | Signed overflow flag |

## Verification
The assertions assume that the output register is present. They also assume that the operands and mode are known (not X) on every clock edge after reset, since each check compares registered outputs with the inputs sampled one cycle earlier. The stimulus keeps to this by changing inputs only on the falling edge and driving every operand bit on every cycle. At width 4 the stimulus covers every operand, mode and carry combination. At width 16 it uses random operands plus directed cases built around the most negative value.

// File: rtl/addsubPkg.sv
package addsubPkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic invB;  // complement the second operand
    logic cin0;  // carry into bit 0
  } addsubCtrlT;

  // Copy bit srcW-1 of v into every position at or above srcW.
  function automatic logic [63:0] signExtend(input logic [63:0] v, input int unsigned srcW);
    logic [63:0] o;
    for (int i = 0; i < 64; i++) begin
      o[i] = (i < srcW) ? v[i] : v[srcW-1];
    end
    return o;
  endfunction

endpackage

// File: rtl/addsubCtrl.sv
module addsubCtrl
  import addsubPkg::*;
(
  input  logic       subMode,
  input  logic       carryIn,
  output addsubCtrlT ctrl
);
  always_comb begin
    ctrl.invB = subMode;
    // Subtract: the +1 of the two's complement replaces the external carry.
    ctrl.cin0 = subMode ? 1'b1 : carryIn;
  end
endmodule

// File: rtl/addsubDatapath.sv
module addsubDatapath
  import addsubPkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  addsubCtrlT   ctrl,
  output logic [W-1:0] sumOut,
  output logic         carryTop,
  output logic         ovfCarry,
  output logic         ovfDouble
);
  localparam int NGRP = W / 4;

  logic [W-1:0] xv, yv;
  logic [W:0]   cv;

  assign xv    = opA;
  assign yv    = opB ^ {W{ctrl.invB}};
  assign cv[0] = ctrl.cin0;

  for (genvar grp = 0; grp < NGRP; grp++) begin : gSlice
    localparam int B = grp * 4;
    logic [3:0] gg, pp;
    assign gg = xv[B +: 4] & yv[B +: 4];
    assign pp = xv[B +: 4] | yv[B +: 4];
    // Two-level carry expressions; only cv[B] crosses from the slice below.
    assign cv[B+1] = gg[0] | (pp[0] & cv[B]);
    assign cv[B+2] = gg[1] | (pp[1] & gg[0]) | (pp[1] & pp[0] & cv[B]);
    assign cv[B+3] = gg[2] | (pp[2] & gg[1]) | (pp[2] & pp[1] & gg[0])
                   | (pp[2] & pp[1] & pp[0] & cv[B]);
    assign cv[B+4] = gg[3] | (pp[3] & gg[2]) | (pp[3] & pp[2] & gg[1])
                   | (pp[3] & pp[2] & pp[1] & gg[0])
                   | (pp[3] & pp[2] & pp[1] & pp[0] & cv[B]);
  end

  assign sumOut   = xv ^ yv ^ cv[W-1:0];
  assign carryTop = cv[W];
  assign ovfCarry = cv[W] ^ cv[W-1];

  // Second overflow check: one duplicated sign bit on each operand.
  logic [W:0] dblSum;
  assign dblSum    = {xv[W-1], xv} + {yv[W-1], yv} + {{W{1'b0}}, ctrl.cin0};
  assign ovfDouble = dblSum[W] ^ dblSum[W-1];
endmodule

// File: rtl/addsubTop.sv
module addsubTop
  import addsubPkg::*;
#(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         subMode,
  input  logic         carryIn,
  output logic [W-1:0] result,
  output logic         carryOut,
  output logic         overflow
);
  addsubCtrlT   ctrl;
  logic [W-1:0] sumNext;
  logic         carryNext, ovfCarry, ovfDouble;

  addsubCtrl uCtrl (
    .subMode (subMode),
    .carryIn (carryIn),
    .ctrl    (ctrl)
  );

  addsubDatapath #(.W(W)) uPath (
    .opA       (opA),
    .opB       (opB),
    .ctrl      (ctrl),
    .sumOut    (sumNext),
    .carryTop  (carryNext),
    .ovfCarry  (ovfCarry),
    .ovfDouble (ovfDouble)
  );

  if (REG_OUT) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        result   <= '0;
        carryOut <= 1'b0;
        overflow <= 1'b0;
      end else begin
        result   <= sumNext;
        carryOut <= carryNext;
        overflow <= ovfCarry;
      end
    end
  end else begin : gComb
    assign result   = sumNext;
    assign carryOut = carryNext;
    assign overflow = ovfCarry;
  end
endmodule

// File: rtl/addsubChecker.sv
module addsubChecker #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rstN,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         subMode,
  input logic         carryIn,
  input logic [W-1:0] result,
  input logic         carryOut,
  input logic         overflow,
  input logic         ovfCarry,
  input logic         ovfDouble
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic seen;
  always_ff @(posedge clk) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  AST_OVF_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    ovfCarry == ovfDouble);  // R4

  if (REG_OUT) begin : gSeq
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rstN) |-> (result == '0 && !carryOut && !overflow));  // R6
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rstN)
      (seen && !$past(subMode)) |->
        ({carryOut, result} == ((W+1)'($past(opA)) + (W+1)'($past(opB)) + (W+1)'($past(carryIn)))));  // R1
    AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rstN)
      (seen && $past(subMode)) |-> (result == W'($past(opA) - $past(opB))));  // R2
    AST_OVF_SIGN: assert property (@(posedge clk) disable iff (!rstN)
      (seen && overflow) |-> (result[W-1] != $past(opA[W-1])));  // R3
    AST_MIN_NEGATE: assert property (@(posedge clk) disable iff (!rstN)
      (seen && $past(subMode) && $past(opA) == '0 && $past(opB) == MINV) |->
        (overflow && result == MINV));  // R5
  end
endmodule

bind addsubTop addsubChecker #(.W(W), .REG_OUT(REG_OUT)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .opA       (opA),
  .opB       (opB),
  .subMode   (subMode),
  .carryIn   (carryIn),
  .result    (result),
  .carryOut  (carryOut),
  .overflow  (overflow),
  .ovfCarry  (ovfCarry),
  .ovfDouble (ovfDouble)
);

// File: tb/addsubTop_test.sv
`timescale 1ns/1ps
module addsubTop_test;
  import addsubPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] aW, bW, resW;
  logic        subW, cinW, coW, ovW;
  logic [3:0]  aN, bN, resN;
  logic        subN, cinN, coN, ovN;

  addsubTop #(.W(16)) uut (
    .clk(clk), .rstN(rstN), .opA(aW), .opB(bW), .subMode(subW), .carryIn(cinW),
    .result(resW), .carryOut(coW), .overflow(ovW));

  addsubTop #(.W(4)) uutNarrow (
    .clk(clk), .rstN(rstN), .opA(aN), .opB(bN), .subMode(subN), .carryIn(cinN),
    .result(resN), .carryOut(coN), .overflow(ovN));

  typedef struct {
    bit          narrow;
    logic [15:0] res;
    logic        co;
    logic        ov;
    string       tag;
  } expT;

  expT sbq[$];
  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  function automatic expT model(bit narrow, logic [15:0] a, logic [15:0] b, logic sub, logic cin);
    expT e;
    int unsigned w = narrow ? 4 : 16;
    longint mask = (longint'(1) << w) - 1;
    longint sa = $signed(signExtend(64'(a), w));
    longint sb = $signed(signExtend(64'(b), w));
    longint lim = longint'(1) << (w - 1);
    longint s = sa + (sub ? -sb : sb) + (sub ? 0 : longint'(cin));
    longint ua = longint'(a) & mask;
    longint ub = longint'(b) & mask;
    longint u = ua + (sub ? (~ub & mask) : ub) + (sub ? 1 : longint'(cin));
    e.narrow = narrow;
    e.res    = 16'(s & mask);
    e.ov     = (s >= lim) || (s < -lim);
    e.co     = u[w];
    if (ua == lim || ub == lim) e.tag = "R5";
    else if (sub)               e.tag = "R2";
    else                        e.tag = "R1";
    return e;
  endfunction

  task automatic drive(bit narrow, logic [15:0] a, logic [15:0] b, logic sub, logic cin);
    @(negedge clk);
    if (narrow) begin aN = a[3:0]; bN = b[3:0]; subN = sub; cinN = cin; end
    else        begin aW = a;      bW = b;      subW = sub; cinW = cin; end
    sbq.push_back(model(narrow, a, b, sub, cin));
  endtask

  // Monitor: one registered result per pushed item, one cycle after it is driven (R6).
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      expT e = sbq.pop_front();
      logic [15:0] r = e.narrow ? {12'b0, resN} : resW;
      logic co = e.narrow ? coN : coW;
      logic ov = e.narrow ? ovN : ovW;
      checks += 3;
      if (r !== e.res) begin
        failures++;
        $display("FAIL %s R6 result actual=%h expected=%h", e.tag, r, e.res);
      end
      if (co !== e.co) begin
        failures++;
        $display("FAIL %s carryOut actual=%b expected=%b", e.tag, co, e.co);
      end
      if (ov !== e.ov) begin
        failures++;
        $display("FAIL R3 R4 %s overflow actual=%b expected=%b", e.tag, ov, e.ov);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    aW = 16'hA5A5; bW = 16'h7FFF; subW = 1'b0; cinW = 1'b1;
    aN = 4'hF;     bN = 4'h7;     subN = 1'b1; cinN = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (resW !== 16'h0 || coW !== 1'b0 || ovW !== 1'b0 || resN !== 4'h0 || coN !== 1'b0 || ovN !== 1'b0) begin
      failures++;
      $display("FAIL R6 reset outputs actual=%h/%b/%b expected=0000/0/0", resW, coW, ovW);
    end
    @(negedge clk);
    rstN = 1'b1;

    // Exhaustive narrow sweep: every operand, mode and carry-in (R1 R2 R3 R5).
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 2; c++)
            drive(1'b1, 16'(a), 16'(b), s[0], c[0]);

    // Directed wide corners around the most negative value (R5).
    drive(1'b0, 16'h0000, 16'h8000, 1'b1, 1'b0);
    drive(1'b0, 16'h0000, 16'h8000, 1'b1, 1'b1);
    drive(1'b0, 16'h8000, 16'h0001, 1'b1, 1'b0);
    drive(1'b0, 16'h8000, 16'h8000, 1'b0, 1'b0);
    drive(1'b0, 16'h7FFF, 16'h0001, 1'b0, 1'b0);
    drive(1'b0, 16'h7FFF, 16'h0000, 1'b0, 1'b1);
    drive(1'b0, 16'hFFFF, 16'h0001, 1'b0, 1'b0);
    drive(1'b0, 16'h8000, 16'hFFFF, 1'b1, 1'b1);

    // Random wide operands in both modes.
    for (int i = 0; i < 3000; i++)
      drive(1'b0, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule